// File: doc/BRIEF.md
# Single-Bit Run-Length Prefix Encoder

This block compresses one sampled logic channel into a stream of short prefix codes. A sampler upstream delivers one bit per clock with a valid strobe. The encoder counts runs of identical samples and describes each run with a 2-to-4 bit code. Each code gives the run's length and says whether the level flips at its end. Before any run code, a single header bit gives the level of the first sample. The coding assumes every run lasts at least seven samples, which is the case when the sampler is clocked several times faster than the fastest edge rate of the signal. This keeps the code stream well under half of the raw sample rate.

Runs are coded as follows. Seven samples followed by a flip is `01`. Eight or nine samples followed by a flip is `100` or `101`. Ten to thirteen samples followed by a flip is `1100` to `1111`. Seven samples with no flip is `00`. The encoder has no lookahead. When a run reaches fourteen samples, it emits `00` for seven of them and keeps counting from seven, so the remainder that ends at a flip always lies between seven and thirteen.

A run shorter than seven samples cannot be represented. When one ends, the encoder raises a sticky error flag and still emits `01` so that a decoder stays aligned on code boundaries. Each code leaves as a right-aligned value with a length field and a valid strobe, and the first transmitted bit is the value's most significant bit within that length.

Top module: `rle_prefix_enc`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `code_valid` and `err_short` are 0.
- R2: The first valid sample after reset produces exactly one header code: `code_len`=1 and `code_bits`=the sample value. No later sample produces a length-1 code until the next reset.
- R3: A cycle with `smp_valid`=0 produces no code in the following cycle, whatever `smp_bit` is, and does not change the run being counted.
- R4: A run of exactly seven samples ended by a flip is coded `code_bits`=4'b0001, `code_len`=2.
- R5: A run of eight or nine samples ended by a flip is coded 4'b0100 or 4'b0101 respectively, with `code_len`=3.
- R6: A run of ten, eleven, twelve or thirteen samples ended by a flip is coded 4'b1100, 4'b1101, 4'b1110 or 4'b1111 respectively, with `code_len`=4.
- R7: On the fourteenth consecutive same-level sample the encoder emits `code_bits`=4'b0000, `code_len`=2 and counts seven samples as still pending. As a result, any run of L ≥ 7 yields floor((L-7)/7) such codes, then the flip code for the remaining L-7·floor((L-7)/7) samples.
- R8: A flip that ends a run of one to six samples emits `code_bits`=4'b0001, `code_len`=2 and sets `err_short` in the same cycle. `err_short` then stays 1 until reset.
- R9: A code appears in the cycle right after the valid sample that causes it (the header sample, the flipping sample, or the fourteenth sample). At most one code is emitted per cycle, and samples that continue a run below fourteen emit nothing.
- R10: Reset clears `err_short` and re-arms the header, so the next valid sample again produces a header code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_bit | input | 1 | Sampled channel level |
| code_valid | output | 1 | A code is presented this cycle |
| code_bits | output | 4 | Right-aligned code value, MSB sent first |
| code_len | output | 3 | Number of valid code bits (1 to 4) |
| err_short | output | 1 | Sticky flag: a run shorter than seven samples was seen |

## Verification
The bench sweeps run lengths from 7 to 33 at both levels. It predicts the number of split codes, the remainder code and the sample index at which each code must appear, and it decodes the emitted stream back into samples for comparison with the input. A design that split at the wrong count, split one sample late, or chose a remainder code off by one would misplace codes or corrupt the decoded stream. Idle cycles with the opposite level on the data input are inserted in half the runs; an encoder that ignored the strobe would emit spurious flip codes there. Short runs of one to six samples check that the error flag rises together with a `01` code and survives later traffic until reset, and that reset brings back the header.

// File: rtl/rle_pkg.sv
package rle_pkg;

    localparam int CNT_W    = 4;
    localparam int CODE_W   = 4;
    localparam int LEN_W    = 3;
    localparam int MIN_RUN  = 7;
    localparam int MAX_RUN  = 13;
    localparam int SPLIT_AT = MAX_RUN + 1;
    localparam int CARRY    = SPLIT_AT - MIN_RUN;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_HDR,
        EV_SPLIT,
        EV_END
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e         kind;
        logic             lvl;
        logic [CNT_W-1:0] run;
    } run_ev_t;

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] bits;
        logic [LEN_W-1:0]  len;
    } code_t;

    // Flip code for a finished run; runs of seven or fewer map to 01.
    function automatic code_t end_code(input logic [CNT_W-1:0] run);
        code_t c;
        c.vld = 1'b1;
        if (run <= CNT_W'(MIN_RUN)) begin
            c.bits = 4'b0001;
            c.len  = 3'd2;
        end else if (run < CNT_W'(MIN_RUN + 3)) begin
            c.bits = {3'b010, run[0]};
            c.len  = 3'd3;
        end else begin
            c.bits = {2'b11, run[1:0] - 2'b10};
            c.len  = 3'd4;
        end
        return c;
    endfunction

endpackage

// File: rtl/rle_run_track.sv
module rle_run_track
    import rle_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    smp_valid,
    input  logic    smp_bit,
    output run_ev_t ev
);

    logic             hdr_pend;
    logic             lvl;
    logic [CNT_W-1:0] cnt;

    logic             nxt_pend;
    logic             nxt_lvl;
    logic [CNT_W-1:0] nxt_cnt;

    always_comb begin
        ev.kind  = EV_NONE;
        ev.lvl   = lvl;
        ev.run   = cnt;
        nxt_pend = hdr_pend;
        nxt_lvl  = lvl;
        nxt_cnt  = cnt;
        if (smp_valid) begin
            if (hdr_pend) begin
                ev.kind  = EV_HDR;
                ev.lvl   = smp_bit;
                nxt_pend = 1'b0;
                nxt_lvl  = smp_bit;
                nxt_cnt  = CNT_W'(1);
            end else if (smp_bit != lvl) begin
                ev.kind = EV_END;
                nxt_lvl = smp_bit;
                nxt_cnt = CNT_W'(1);
            end else if (cnt == CNT_W'(MAX_RUN)) begin
                ev.kind = EV_SPLIT;
                nxt_cnt = CNT_W'(CARRY);
            end else begin
                nxt_cnt = cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_pend <= 1'b1;
            lvl      <= 1'b0;
            cnt      <= '0;
        end else begin
            hdr_pend <= nxt_pend;
            lvl      <= nxt_lvl;
            cnt      <= nxt_cnt;
        end
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !hdr_pend |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(MAX_RUN)));

    // R2
    hdr_once_chk: assert property (@(posedge clk) disable iff (rst)
        !hdr_pend |=> !hdr_pend);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(cnt) && $stable(lvl)));

endmodule

// File: rtl/rle_code_map.sv
module rle_code_map
    import rle_pkg::*;
(
    input  run_ev_t ev,
    output code_t   code,
    output logic    short_run
);

    always_comb begin
        code      = '0;
        short_run = 1'b0;
        unique case (ev.kind)
            EV_HDR: begin
                code.vld  = 1'b1;
                code.bits = {{(CODE_W-1){1'b0}}, ev.lvl};
                code.len  = LEN_W'(1);
            end
            EV_SPLIT: begin
                code.vld  = 1'b1;
                code.bits = '0;
                code.len  = LEN_W'(2);
            end
            EV_END: begin
                code      = end_code(ev.run);
                short_run = (ev.run < CNT_W'(MIN_RUN));
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rle_emit_reg.sv
module rle_emit_reg
    import rle_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t code_d,
    input  logic  short_d,
    output code_t code_q,
    output logic  err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            err_q  <= 1'b0;
        end else begin
            code_q <= code_d;
            if (short_d) err_q <= 1'b1;
        end
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R9
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        code_q.vld |-> (code_q.len >= LEN_W'(1) && code_q.len <= LEN_W'(CODE_W)
                        && (code_q.bits >> code_q.len) == '0));

endmodule

// File: rtl/rle_prefix_enc.sv
module rle_prefix_enc
    import rle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic              smp_bit,
    output logic              code_valid,
    output logic [CODE_W-1:0] code_bits,
    output logic [LEN_W-1:0]  code_len,
    output logic              err_short
);

    run_ev_t ev;
    code_t   code_d;
    code_t   code_q;
    logic    short_d;

    rle_run_track u_track (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_bit   (smp_bit),
        .ev        (ev)
    );

    rle_code_map u_map (
        .ev        (ev),
        .code      (code_d),
        .short_run (short_d)
    );

    rle_emit_reg u_emit (
        .clk     (clk),
        .rst     (rst),
        .code_d  (code_d),
        .short_d (short_d),
        .code_q  (code_q),
        .err_q   (err_short)
    );

    assign code_valid = code_q.vld;
    assign code_bits  = code_q.bits;
    assign code_len   = code_q.len;

    // R9
    code_follows_sample_chk: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(smp_valid));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !code_valid);

    // R8
    err_with_01_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_short) |-> (code_valid && code_len == LEN_W'(2)
                              && code_bits == CODE_W'(1)));

    // R2
    hdr_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code_len == LEN_W'(1)) |-> code_bits[CODE_W-1:1] == '0);

endmodule

// File: tb/rle_prefix_enc_test.sv
module rle_prefix_enc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic       smp_bit = 1'b0;
    logic       code_valid;
    logic [3:0] code_bits;
    logic [2:0] code_len;
    logic       err_short;

    rle_prefix_enc uut (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_bit    (smp_bit),
        .code_valid (code_valid),
        .code_bits  (code_bits),
        .code_len   (code_len),
        .err_short  (err_short)
    );

    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    logic       in_s [0:127];
    logic       dq   [0:127];
    logic [3:0] cb   [0:15];
    int         cl   [0:15];
    int         cp   [0:15];
    int         nin;
    int         ncode;
    logic       xl;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, observe 5 ns after the rising edge.
    task automatic cycle(input bit v, input bit b);
        int idx;
        smp_valid = v;
        smp_bit   = b;
        @(posedge clk);
        #5;
        idx = -1;
        if (v && nin < 128) begin
            in_s[nin] = b;
            idx = nin;
            nin++;
        end
        if (code_valid) begin
            if (idx < 0)
                chk(1'b0, "R3 code after idle cycle", 1, 0);
            else if (ncode < 16) begin
                cb[ncode] = code_bits;
                cl[ncode] = int'(code_len);
                cp[ncode] = idx;
                ncode++;
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        nin = 0;
        ncode = 0;
    endtask

    function automatic int exp_bits(input int r);
        if (r == 7) return 1;
        if (r < 10) return 4 + (r - 8);
        return 12 + (r - 10);
    endfunction

    function automatic int exp_len(input int r);
        if (r == 7) return 2;
        if (r < 10) return 3;
        return 4;
    endfunction

    // Rebuild samples from the captured codes and compare with the input.
    task automatic decode_check(input int exp_n);
        logic cur;
        int   nd;
        int   n;
        bit   tog;
        bit   ok;
        cur = 1'b0;
        nd  = 0;
        for (int k = 0; k < ncode; k++) begin
            n = 0;
            tog = 1'b0;
            if (cl[k] == 1) cur = cb[k][0];
            else if (cl[k] == 2) begin n = 7; tog = cb[k][0]; end
            else if (cl[k] == 3) begin n = 8 + int'(cb[k][0]); tog = 1'b1; end
            else begin n = 10 + int'(cb[k][1:0]); tog = 1'b1; end
            for (int j = 0; j < n; j++) begin
                if (nd < 128) dq[nd] = cur;
                nd++;
            end
            if (tog) cur = ~cur;
        end
        chk(nd == exp_n, "R7 decoded sample count", nd, exp_n);
        ok = 1'b1;
        for (int j = 0; j < exp_n && j < 128; j++)
            if (dq[j] !== in_s[j]) ok = 1'b0;
        chk(ok, "R7 decoded stream matches input", int'(ok), 1);
    endtask

    initial begin
        do_reset();
        // R1: outputs quiet right after reset
        chk(code_valid == 1'b0, "R1 code_valid after reset", int'(code_valid), 0);
        chk(err_short == 1'b0, "R1 err_short after reset", int'(err_short), 0);

        // Sweep run lengths at both levels
        for (int L = 7; L <= 33; L++) begin
            for (int xi = 0; xi < 2; xi++) begin
                int  n00;
                int  r;
                int  nh;
                bit  gaps;
                logic b;
                xl   = xi[0];
                gaps = (L % 2) == 1;
                do_reset();
                for (int i = 0; i < L + 8; i++) begin
                    b = (i < L) ? xl : ((i < L + 7) ? ~xl : xl);
                    cycle(1'b1, b);
                    if (gaps && (i % 5) == 4) begin
                        cycle(1'b0, ~b);
                        cycle(1'b0, ~b);
                    end
                end
                n00 = (L - 7) / 7;
                r   = L - 7 * n00;
                chk(ncode == n00 + 3, "R9 code count per sequence", ncode, n00 + 3);
                if (ncode == n00 + 3) begin
                    // R2: header
                    chk(cl[0] == 1 && cb[0] == {3'b000, xl} && cp[0] == 0,
                        "R2 header code", int'(cb[0]), int'(xl));
                    nh = 0;
                    for (int k = 0; k < ncode; k++) if (cl[k] == 1) nh++;
                    chk(nh == 1, "R2 single header", nh, 1);
                    // R7: split codes at the fourteenth sample and every seventh after
                    for (int k = 0; k < n00; k++)
                        chk(cb[k+1] == 4'b0000 && cl[k+1] == 2 && cp[k+1] == 13 + 7 * k,
                            "R7 split code position", cp[k+1], 13 + 7 * k);
                    // R4 / R5 / R6: remainder code on the flipping sample
                    chk(int'(cb[n00+1]) == exp_bits(r) && cl[n00+1] == exp_len(r),
                        (r == 7) ? "R4 remainder code" : ((r < 10) ? "R5 remainder code" : "R6 remainder code"),
                        int'(cb[n00+1]), exp_bits(r));
                    chk(cp[n00+1] == L, "R9 flip code timing", cp[n00+1], L);
                    // R4: seven-sample second run
                    chk(cb[n00+2] == 4'b0001 && cl[n00+2] == 2 && cp[n00+2] == L + 7,
                        "R4 seven-run code", int'(cb[n00+2]), 1);
                end
                decode_check(L + 7);
                chk(err_short == 1'b0, "R8 no error on legal runs", int'(err_short), 0);
            end
        end

        // Short runs of one to six samples
        for (int s = 1; s <= 6; s++) begin
            do_reset();
            for (int i = 0; i < s; i++) cycle(1'b1, 1'b1);
            cycle(1'b1, 1'b0);
            chk(ncode == 2 && cb[1] == 4'b0001 && cl[1] == 2 && cp[1] == s,
                "R8 short run emits 01", (ncode == 2) ? int'(cb[1]) : -1, 1);
            chk(err_short == 1'b1, "R8 error raised with code", int'(err_short), 1);
            for (int i = 0; i < 9; i++) cycle(1'b1, 1'b0);
            cycle(1'b1, 1'b1);
            cycle(1'b0, 1'b0);
            chk(err_short == 1'b1, "R8 error stays set", int'(err_short), 1);
            // R10: reset clears error and rearms header
            do_reset();
            chk(err_short == 1'b0, "R10 reset clears error", int'(err_short), 1'b0);
            cycle(1'b1, 1'b0);
            chk(ncode == 1 && cl[0] == 1 && cb[0] == 4'b0000,
                "R10 header after reset", ncode, 1);
        end

        // R3: long idle stretch with a flipping data input between valid samples
        do_reset();
        for (int i = 0; i < 10; i++) begin
            cycle(1'b1, 1'b1);
            cycle(1'b0, 1'b0);
            cycle(1'b0, 1'b1);
        end
        cycle(1'b1, 1'b0);
        chk(ncode == 2 && int'(cb[1]) == exp_bits(10) && cl[1] == 4,
            "R3 idle cycles do not break run", (ncode == 2) ? int'(cb[1]) : -1, exp_bits(10));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule